// File: doc/BRIEF.md
# Radix-4 FFT Frame Sequencer

This block holds the control and index logic that sits around a five-stage radix-4 transform engine of 1024 points. A one-cycle start pulse opens a frame. The forward or inverse choice is captured together with that pulse. The block then takes in 1024 complex samples on back-to-back clocks and keeps a busy flag high for the input side. When the engine's processing delay has passed, it streams out 1024 results under a valid strobe.

The engine emits its results in base-4 digit-reversed order. For each output sample the sequencer therefore reports the natural-order frequency index, which is the output counter with its 2-bit digits placed in reverse order.

A small stub stands in for the engine's arithmetic so that the output data path carries values that can be checked. It accumulates the frame's input samples and combines that sum with the engine-order counter and the latched mode.

Top module: `fft_frame_seq`

## Requirements
- R1: After a synchronous active-high reset, busy, dout_valid, dout_pos, dout_re and dout_im are all 0.
- R2: A start seen while busy is low is accepted, and busy is high from the next cycle. Busy stays high through intake, processing and output, and drops in the cycle after the last valid output. A start in that first low cycle opens the next frame.
- R3: A start seen while busy is high is ignored. The frame in progress keeps its sample count, its mode and its output timing.
- R4: The mode (invert: 0 forward, 1 inverse) is captured only in the cycle of an accepted start. Later changes to invert have no effect until the next accepted start.
- R5: Exactly 1024 input samples are taken, one per clock, in the 1024 cycles directly after the accepted start.
- R6: The first valid output appears exactly LATENCY cycles (parameter, at least 2, default 16) after the cycle that carries the last input sample.
- R7: dout_valid is high for exactly 1024 consecutive cycles per frame and is high only while busy is high.
- R8: The k-th output of a frame (k = 0..1023) carries dout_pos equal to k with its five 2-bit digits in reverse order. Bits [1:0] of dout_pos are k[9:8], bits [3:2] are k[7:6], and so on, and the bit order inside each digit is kept.
- R9: dout_pos, dout_re and dout_im are 0 in every cycle where dout_valid is low, so the position returns to 0 after the last output.
- R10: With the sums SI and SQ of the frame's sign-extended input samples, taken modulo 2^(WIDTH+2), the k-th output has dout_re = SI + k. In forward mode dout_im = SQ + k, and in inverse mode dout_im = SQ − k. Both are WIDTH+2 bits wide, modulo 2^(WIDTH+2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse in the cycle before the first sample |
| invert | input | 1 | Mode select: 0 forward, 1 inverse; sampled with an accepted start |
| din_re | input | WIDTH | Real part of the input sample, signed |
| din_im | input | WIDTH | Imaginary part of the input sample, signed |
| busy | output | 1 | High while a frame is taken in, processed or output |
| dout_valid | output | 1 | High on each cycle that carries an output sample |
| dout_re | output | WIDTH+2 | Real part of the output sample |
| dout_im | output | WIDTH+2 | Imaginary part of the output sample |
| dout_pos | output | 2*NDIG | Natural-order frequency index of the output sample |

## Verification
The hardest cases to reach are those where the sequencer must hold its state against disturbance. One is a stray start pulse or a flip of the mode input while a frame is already running. The other is a new start landing in the very first cycle after busy falls. The stimulus fires a start pulse midway through intake and again during output, and it flips invert a few samples into each frame. It also launches the next frame on the first idle cycle it observes. The behavioural model in the bench then has to agree with the outputs in every cycle of all these frames.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_WAIT  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_t;

    typedef struct packed {
        logic clear;
        logic load;
        logic inv;
    } stub_ctl_t;

    function automatic logic phase_busy(phase_t p);
        return p != PH_IDLE;
    endfunction

    function automatic logic phase_out(phase_t p);
        return p == PH_DRAIN;
    endfunction

endpackage

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
    import fft_seq_pkg::*;
#(
    parameter int NDIG    = 5,
    parameter int LATENCY = 16,
    localparam int IDXW   = 2 * NDIG,
    localparam int NPTS   = 1 << IDXW,
    localparam int WCW    = $clog2(LATENCY) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            invert,
    output phase_t          phase,
    output logic [IDXW-1:0] ocnt,
    output stub_ctl_t       ctl
);

    logic [IDXW-1:0] icnt;
    logic [WCW-1:0]  wcnt;
    logic            mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            icnt  <= '0;
            ocnt  <= '0;
            wcnt  <= '0;
            mode  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOAD;
                        icnt  <= '0;
                        mode  <= invert;
                    end
                end
                PH_LOAD: begin
                    icnt <= icnt + 1'b1;
                    if (icnt == IDXW'(NPTS - 1)) begin
                        phase <= PH_WAIT;
                        wcnt  <= '0;
                    end
                end
                PH_WAIT: begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == WCW'(LATENCY - 2)) begin
                        phase <= PH_DRAIN;
                        ocnt  <= '0;
                    end
                end
                default: begin
                    ocnt <= ocnt + 1'b1;
                    if (ocnt == IDXW'(NPTS - 1)) begin
                        phase <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        ctl.clear = (phase == PH_IDLE) && start;
        ctl.load  = (phase == PH_LOAD);
        ctl.inv   = mode;
    end

    p_accept_start_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> (phase == PH_LOAD && icnt == '0));

    p_stray_start_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && start) |=> (icnt == IDXW'($past(icnt) + 1'b1)));

    p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> $stable(mode));

    p_drain_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DRAIN && $past(phase) != PH_DRAIN) |-> (ocnt == '0));

    p_drain_after_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DRAIN && $past(phase) != PH_DRAIN) |-> ($past(phase) == PH_WAIT));

endmodule

// File: rtl/fft_seq_posgen.sv
module fft_seq_posgen #(
    parameter int NDIG  = 5,
    localparam int IDXW = 2 * NDIG
) (
    input  logic            valid,
    input  logic [IDXW-1:0] cnt,
    output logic [IDXW-1:0] pos
);

    logic [IDXW-1:0] rev;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        assign rev[2*g +: 2] = cnt[2*(NDIG-1-g) +: 2];
    end

    always_comb begin
        pos = valid ? rev : '0;
    end

endmodule

// File: rtl/fft_seq_stub.sv
module fft_seq_stub
    import fft_seq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDXW  = 10,
    localparam int OW   = WIDTH + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  stub_ctl_t               ctl,
    input  logic signed [WIDTH-1:0] iin,
    input  logic signed [WIDTH-1:0] qin,
    input  logic                    valid,
    input  logic [IDXW-1:0]         k,
    output logic [OW-1:0]           iout,
    output logic [OW-1:0]           qout
);

    logic [OW-1:0] acc_i;
    logic [OW-1:0] acc_q;
    logic [OW-1:0] kk;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            acc_i <= '0;
            acc_q <= '0;
        end else if (ctl.load) begin
            acc_i <= acc_i + OW'(iin);
            acc_q <= acc_q + OW'(qin);
        end
    end

    always_comb begin
        kk   = OW'(k);
        iout = '0;
        qout = '0;
        if (valid) begin
            iout = acc_i + kk;
            qout = ctl.inv ? (acc_q - kk) : (acc_q + kk);
        end
    end

endmodule

// File: rtl/fft_frame_seq.sv
module fft_frame_seq
    import fft_seq_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int NDIG    = 5,
    parameter int LATENCY = 16,
    localparam int IDXW   = 2 * NDIG,
    localparam int OW     = WIDTH + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             invert,
    input  logic [WIDTH-1:0] din_re,
    input  logic [WIDTH-1:0] din_im,
    output logic             busy,
    output logic             dout_valid,
    output logic [OW-1:0]    dout_re,
    output logic [OW-1:0]    dout_im,
    output logic [IDXW-1:0]  dout_pos
);

    phase_t          phase;
    logic [IDXW-1:0] ocnt;
    stub_ctl_t       ctl;

    fft_seq_ctrl #(.NDIG(NDIG), .LATENCY(LATENCY)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .invert (invert),
        .phase  (phase),
        .ocnt   (ocnt),
        .ctl    (ctl)
    );

    always_comb begin
        busy       = phase_busy(phase);
        dout_valid = phase_out(phase);
    end

    fft_seq_posgen #(.NDIG(NDIG)) u_pos (
        .valid (dout_valid),
        .cnt   (ocnt),
        .pos   (dout_pos)
    );

    fft_seq_stub #(.WIDTH(WIDTH), .IDXW(IDXW)) u_stub (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .iin   (din_re),
        .qin   (din_im),
        .valid (dout_valid),
        .k     (ocnt),
        .iout  (dout_re),
        .qout  (dout_im)
    );

    p_valid_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> busy);

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !dout_valid |-> (dout_pos == '0 && dout_re == '0 && dout_im == '0));

    p_busy_drop_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(dout_valid));

endmodule

// File: tb/sim_fft_frame_seq.sv
module sim_fft_frame_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH = 8;
    localparam int NDIG  = 5;
    localparam int LAT   = 16;
    localparam int IDXW  = 2 * NDIG;
    localparam int NPTS  = 1 << IDXW;
    localparam int OW    = WIDTH + 2;
    localparam int MASK  = (1 << OW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic invert = 1'b0;
    logic [WIDTH-1:0] din_re = '0;
    logic [WIDTH-1:0] din_im = '0;
    logic busy, dout_valid;
    logic [OW-1:0] dout_re, dout_im;
    logic [IDXW-1:0] dout_pos;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_in = 0;
    int run_len = 0;
    bit prev_valid = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int m_st = 0;
    int m_n = 0;
    int m_si = 0;
    int m_sq = 0;
    bit m_inv = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fft_frame_seq #(.WIDTH(WIDTH), .NDIG(NDIG), .LATENCY(LAT)) u0 (
        .clk(clk), .rst(rst), .start(start), .invert(invert),
        .din_re(din_re), .din_im(din_im), .busy(busy),
        .dout_valid(dout_valid), .dout_re(dout_re), .dout_im(dout_im),
        .dout_pos(dout_pos)
    );

    function automatic int rev4(int k);
        int r = 0;
        int v = k;
        for (int d = 0; d < NDIG; d++) begin
            r = r * 4 + (v % 4);
            v = v / 4;
        end
        return r;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 0;
            m_n = 0;
        end else begin
            case (m_st)
                0: if (start) begin
                    m_st = 1; m_n = 0; m_inv = invert; m_si = 0; m_sq = 0;
                end
                1: begin
                    m_si += int'($signed(din_re));
                    m_sq += int'($signed(din_im));
                    m_n++;
                    if (m_n == NPTS) begin m_st = 2; m_n = 0; end
                end
                2: begin
                    m_n++;
                    if (m_n == LAT - 1) begin m_st = 3; m_n = 0; end
                end
                default: begin
                    m_n++;
                    if (m_n == NPTS) begin m_st = 0; m_n = 0; end
                end
            endcase
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ev;
            ev = (m_st == 3);
            chk("R2 busy", int'(busy), int'(m_st != 0));
            chk("R7 valid", int'(dout_valid), int'(ev));
            chk("R8/R9 position", int'(dout_pos), ev ? rev4(m_n) : 0);
            chk("R10/R9 real", int'(dout_re), ev ? ((m_si + m_n) & MASK) : 0);
            chk("R10/R4 imag", int'(dout_im),
                ev ? ((m_inv ? (m_sq - m_n) : (m_sq + m_n)) & MASK) : 0);
            if (dout_valid && !prev_valid) begin
                chk("R6 latency", cyc - last_in, LAT);
                run_len = 0;
            end
            if (dout_valid) run_len++;
            if (!dout_valid && prev_valid) chk("R7 run length", run_len, NPTS);
            prev_valid = dout_valid;
        end
    end

    function automatic logic [WIDTH-1:0] pat_re(int pat, int i);
        case (pat)
            0: return WIDTH'(i);
            1: return (i % 2 == 0) ? 8'h7f : 8'h80;
            default: return WIDTH'(i * 37 + 11);
        endcase
    endfunction

    function automatic logic [WIDTH-1:0] pat_im(int pat, int i);
        case (pat)
            0: return WIDTH'(-i);
            1: return (i % 3 == 0) ? 8'h80 : 8'h7f;
            default: return WIDTH'(i * 91 + 5);
        endcase
    endfunction

    // R5: samples follow start on consecutive clocks; R3 and R4 pokes inside
    task automatic run_frame(bit inv, int pat, bit poke);
        start = 1'b1;
        invert = inv;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < NPTS; i++) begin
            din_re = pat_re(pat, i);
            din_im = pat_im(pat, i);
            if (i == 5) invert = ~inv;
            start = (poke && i == 100);
            if (i == NPTS - 1) last_in = cyc;
            @(negedge clk);
        end
        start = 1'b0;
        din_re = 8'h55;
        din_im = 8'haa;
        for (int w = 0; busy; w++) begin
            start = (poke && (w == 3 || w == 300));
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        for (int w = 0; w < 150000 && !done; w++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk("R1 busy", int'(busy), 0);
        chk("R1 valid", int'(dout_valid), 0);
        chk("R1 pos", int'(dout_pos), 0);
        chk("R1 re", int'(dout_re), 0);
        chk("R1 im", int'(dout_im), 0);
        @(negedge clk);
        run_frame(1'b0, 0, 1'b1);
        // R2: back-to-back start in the first idle cycle
        run_frame(1'b1, 1, 1'b0);
        run_frame(1'b1, 2, 1'b1);
        run_frame(1'b0, 2, 1'b0);
        repeat (5) @(negedge clk);
        chk("R9 pos after frame", int'(dout_pos), 0);
        chk("R2 idle busy", int'(busy), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule